// File: doc/BRIEF.md
# Warp Issue Scheduler with Block Barrier

This block sits inside one multiprocessor and decides, every cycle, which resident warp gets the next issue slot. A block of threads is admitted into one of a fixed number of block slots. Its thread count is cut into warps of a fixed width, with a short final warp still taking a whole warp slot. Each warp is then tracked as resident, waiting on a long-latency operation, or parked at the block barrier.

A warp that starts a long-latency operation drops out of selection until its completion arrives, so the issue slot goes to other warps in the meantime. A warp that reaches the barrier stays parked until every resident warp of its own block has arrived. Then the whole block is released together, while warps of other blocks keep issuing. Among eligible warps the choice rotates round-robin, starting just past the warp issued last.

Admitting a block into a slot replaces whatever that slot held before. Admitting zero threads empties the slot.

Top module: `warp_sched`

## Requirements
- R1: After reset no warp is resident, `issue_valid` is low, and the round-robin search starts at warp 0.
- R2: Admitting T threads into block slot b makes warps 0 to ceil(T/WARP_SIZE)-1 of that slot resident and eligible from the next cycle. A partial last warp counts as a full warp. The other warps of the slot are not resident.
- R3: Among eligible warps, the issued warp is the first eligible one found when counting upward from one past the last issued warp, wrapping at the top.
- R4: A pulse on `lat_start[w]` makes warp w ineligible from the next cycle. A pulse on `lat_done[w]` makes it eligible again from the next cycle. If both pulse in the same cycle, the warp stays waiting.
- R5: A warp that pulses `bar_arrive` is not issued while any other resident warp of its block has not arrived.
- R6: In the cycle the last resident warp of a block arrives, the barrier completes, and all of that block's warps are free of the barrier on the next cycle.
- R7: Barrier state of one block never blocks warps of another block.
- R8: When no warp is eligible, `issue_valid` is low.
- R9: Latency and barrier pulses on warps that are not resident have no effect. A non-resident warp never holds back a barrier release.
- R10: An admit to a slot clears the waiting and barrier state of all that slot's warps and replaces its residency.
- R11: Global warp id is b*(MAX_THREADS/WARP_SIZE)+k for warp k of block slot b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| admit_valid | input | 1 | Admit a block this cycle |
| admit_blk | input | BW | Block slot being admitted |
| admit_threads | input | TW | Thread count of the admitted block (0 to MAX_THREADS) |
| lat_start | input | NW | Per-warp long-latency start pulse |
| lat_done | input | NW | Per-warp long-latency completion pulse |
| bar_arrive | input | NW | Per-warp barrier arrival pulse |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | IW | Global id of the issued warp |

## Verification
The assertions take for granted that admitted thread counts never exceed MAX_THREADS. They also assume block slot indices stay below NUM_BLOCKS. The stimulus respects both: random admits draw counts from 0 to MAX_THREADS and slots from the valid range. Apart from that, the stimulus is free to pulse latency and barrier signals on any warp, resident or not, including on warps already waiting or parked. This exercises the ignore and overlap rules rather than avoiding them.

// File: rtl/warp_sched.sv
module warp_sched #(
  parameter int WARP_SIZE   = 32,
  parameter int MAX_THREADS = 256,
  parameter int NUM_BLOCKS  = 4,
  localparam int WPB = MAX_THREADS / WARP_SIZE,
  localparam int NW  = NUM_BLOCKS * WPB,
  localparam int IW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int BW  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int TW  = $clog2(MAX_THREADS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          admit_valid,
  input  logic [BW-1:0] admit_blk,
  input  logic [TW-1:0] admit_threads,
  input  logic [NW-1:0] lat_start,
  input  logic [NW-1:0] lat_done,
  input  logic [NW-1:0] bar_arrive,
  output logic          issue_valid,
  output logic [IW-1:0] issue_warp
);

  logic [NW-1:0] res_q, wait_q, bar_q;
  logic [IW-1:0] last_q;
  logic [NW-1:0] adm_slot, adm_res, arrived, rel_mask;
  logic [NUM_BLOCKS-1:0] rel_blk;
  logic [NW-1:0] ready;
  int nw;
  int idx;
  logic found;

  assign ready   = res_q & ~wait_q & ~bar_q;
  assign arrived = bar_q | (bar_arrive & res_q);

  always_comb begin
    nw = (int'(admit_threads) + WARP_SIZE - 1) / WARP_SIZE;
    for (int w = 0; w < NW; w++) begin
      adm_slot[w] = admit_valid && ((w / WPB) == int'(admit_blk));
      adm_res[w]  = adm_slot[w] && ((w % WPB) < nw);
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [WPB-1:0] r_s, a_s;
    assign r_s = res_q[b*WPB +: WPB];
    assign a_s = arrived[b*WPB +: WPB];
    assign rel_blk[b] = (|r_s) && (&(a_s | ~r_s));
    assign rel_mask[b*WPB +: WPB] = {WPB{rel_blk[b]}};
  end

  always_comb begin
    found      = 1'b0;
    issue_warp = '0;
    idx        = 0;
    for (int i = 1; i <= NW; i++) begin
      idx = (int'(last_q) + i) % NW;
      if (!found && ready[idx]) begin
        found      = 1'b1;
        issue_warp = IW'(idx);
      end
    end
  end

  assign issue_valid = found;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      wait_q <= '0;
      bar_q  <= '0;
      last_q <= IW'(NW - 1);
    end else begin
      res_q  <= (res_q & ~adm_slot) | adm_res;
      wait_q <= ~adm_slot & res_q & ((wait_q & ~lat_done) | lat_start);
      bar_q  <= ~adm_slot & arrived & ~rel_mask;
      if (issue_valid) last_q <= issue_warp;
    end
  end

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int WARP_SIZE   = 32,
  parameter int MAX_THREADS = 256,
  parameter int NUM_BLOCKS  = 4,
  localparam int WPB = MAX_THREADS / WARP_SIZE,
  localparam int NW  = NUM_BLOCKS * WPB,
  localparam int IW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int BW  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int TW  = $clog2(MAX_THREADS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          admit_valid,
  input logic [BW-1:0] admit_blk,
  input logic [TW-1:0] admit_threads,
  input logic [NW-1:0] lat_start,
  input logic [NW-1:0] lat_done,
  input logic [NW-1:0] bar_arrive,
  input logic          issue_valid,
  input logic [IW-1:0] issue_warp
);

  logic [NW-1:0] p_start, p_done, p_bar;
  logic          p_adm, p_iss, p_rst;
  logic [BW-1:0] p_blk;
  int            cnt [NUM_BLOCKS];
  int            iss_blk, iss_k;

  assign iss_blk = int'(issue_warp) / WPB;
  assign iss_k   = int'(issue_warp) % WPB;

  always_ff @(posedge clk) begin
    p_rst <= rst;
    if (rst) begin
      p_start <= '0; p_done <= '0; p_bar <= '0;
      p_adm <= 1'b0; p_iss <= 1'b0; p_blk <= '0;
      for (int b = 0; b < NUM_BLOCKS; b++) cnt[b] <= 0;
    end else begin
      p_start <= lat_start; p_done <= lat_done; p_bar <= bar_arrive;
      p_adm <= admit_valid; p_iss <= issue_valid; p_blk <= admit_blk;
      if (admit_valid)
        cnt[admit_blk] <= (int'(admit_threads) + WARP_SIZE - 1) / WARP_SIZE;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    p_rst |-> !issue_valid); // R1

  AST_ISSUE_WITHIN_ADMIT: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> iss_k < cnt[iss_blk]); // R2

  AST_NO_ISSUE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (!p_start[issue_warp] || (p_adm && int'(p_blk) == iss_blk))); // R4

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!p_rst && !p_iss && !p_adm && p_done == '0 && p_bar == '0) |-> !issue_valid); // R8

endmodule

bind warp_sched warp_sched_chk #(
  .WARP_SIZE(WARP_SIZE), .MAX_THREADS(MAX_THREADS), .NUM_BLOCKS(NUM_BLOCKS)
) u_chk (.*);

// File: tb/warp_sched_bench.sv
module warp_sched_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int WARP_SIZE   = 32;
  localparam int MAX_THREADS = 256;
  localparam int NUM_BLOCKS  = 4;
  localparam int WPB = MAX_THREADS / WARP_SIZE;
  localparam int NW  = NUM_BLOCKS * WPB;
  localparam int IW  = $clog2(NW);
  localparam int BW  = $clog2(NUM_BLOCKS);
  localparam int TW  = $clog2(MAX_THREADS + 1);

  logic clk = 0, rst = 1;
  logic admit_valid = 0;
  logic [BW-1:0] admit_blk = '0;
  logic [TW-1:0] admit_threads = '0;
  logic [NW-1:0] lat_start = '0, lat_done = '0, bar_arrive = '0;
  logic issue_valid;
  logic [IW-1:0] issue_warp;

  int checks = 0, errors = 0;
  logic [NW-1:0] m_res = '0, m_wait = '0, m_bar = '0;
  int m_last = NW - 1;

  warp_sched #(.WARP_SIZE(WARP_SIZE), .MAX_THREADS(MAX_THREADS), .NUM_BLOCKS(NUM_BLOCKS))
    u_warp_sched (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pick(logic [NW-1:0] rdy, int last);
    for (int i = 1; i <= NW; i++) if (rdy[(last + i) % NW]) return (last + i) % NW;
    return -1;
  endfunction

  task automatic check(string tag, logic ev, int ew);
    checks++;
    if (issue_valid !== ev || (ev && int'(issue_warp) != ew)) begin
      errors++;
      $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0b warp=%0d",
               tag, issue_valid, issue_warp, ev, ew);
    end
  endtask

  task automatic check_model(string tag);
    int e;
    e = pick(m_res & ~m_wait & ~m_bar, m_last);
    check(tag, e >= 0, e < 0 ? 0 : e);
  endtask

  task automatic step();
    int e, nw;
    logic [NW-1:0] as, ar, arr, rel;
    e = pick(m_res & ~m_wait & ~m_bar, m_last);
    if (e >= 0) m_last = e;
    nw = (int'(admit_threads) + WARP_SIZE - 1) / WARP_SIZE;
    for (int w = 0; w < NW; w++) begin
      as[w] = admit_valid && (w / WPB == int'(admit_blk));
      ar[w] = as[w] && (w % WPB < nw);
    end
    arr = m_bar | (bar_arrive & m_res);
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      logic full = 1, any = 0;
      for (int k = 0; k < WPB; k++) begin
        if (m_res[b*WPB+k]) begin any = 1; if (!arr[b*WPB+k]) full = 0; end
      end
      for (int k = 0; k < WPB; k++) rel[b*WPB+k] = any && full;
    end
    m_wait = ~as & m_res & ((m_wait & ~lat_done) | lat_start);
    m_bar  = ~as & arr & ~rel;
    m_res  = (m_res & ~as) | ar;
    @(posedge clk);
    @(negedge clk);
    admit_valid = 0; lat_start = '0; lat_done = '0; bar_arrive = '0;
  endtask

  task automatic admit(int b, int t);
    admit_valid = 1; admit_blk = BW'(b); admit_threads = TW'(t);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset idle", 0, 0);

    admit(1, 33); step();
    check("R2 R11 partial warp, first id", 1, 8);
    step(); check("R3 round robin next", 1, 9);
    lat_start[9] = 1; step(); check("R3 wrap back", 1, 8);
    step(); check("R4 waiting warp skipped", 1, 8);
    lat_done[9] = 1; step(); check("R4 done makes ready", 1, 9);
    lat_start[8] = 1; lat_start[9] = 1; lat_done[9] = 1; step();
    check("R8 none ready", 0, 0);
    lat_done[8] = 1; step(); check("R4 start beats done", 1, 8);
    lat_done[9] = 1; step(); check_model("R4 second done");

    bar_arrive[8] = 1; step(); check("R5 parked warp held", 1, 9);
    step(); check("R5 still held", 1, 9);
    bar_arrive[9] = 1; bar_arrive[10] = 1; step();
    check("R6 R9 release ignores non-resident", 1, 8);
    step(); check("R6 whole block free", 1, 9);

    admit(0, 256); step(); check_model("R2 full block");
    for (int w = 0; w < 7; w++) bar_arrive[w] = 1;
    lat_start[20] = 1; step();
    for (int i = 0; i < 6; i++) begin
      check_model("R7 other blocks keep issuing");
      checks++;
      if (!issue_valid || int'(issue_warp) < 7) begin
        errors++; $display("FAIL R7: got warp=%0d, expected one of 7..9", issue_warp);
      end
      step();
    end
    bar_arrive[7] = 1; step(); check_model("R6 block 0 release");

    lat_start[8] = 1; bar_arrive[9] = 1; step(); check_model("R10 setup");
    admit(1, 64); step(); check_model("R10 readmit clears state");
    step(); check_model("R10 both warps back");
    admit(1, 0); admit_valid = 1; step(); check_model("R10 empty slot");
    admit(0, 0); step(); check("R8 all empty", 0, 0);

    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 40) == 0) admit($urandom_range(0, NUM_BLOCKS-1), $urandom_range(0, MAX_THREADS));
      for (int w = 0; w < NW; w++) begin
        lat_start[w]  = ($urandom_range(0, 15) == 0);
        lat_done[w]   = ($urandom_range(0, 3) == 0);
        bar_arrive[w] = ($urandom_range(0, 20) == 0);
      end
      step();
      check_model("R3 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule